// File: doc/BRIEF.md
# Configurable SPI Register Port

This block is a SPI slave that lets a host read and write a small bank of control registers. Every transaction opens with a 16-bit instruction and then carries one to four data bytes. A configuration register at address 0 controls how the port itself behaves:

- whether read data returns on the shared data line (three-wire) or on a dedicated output line (four-wire);
- whether bits travel most-significant first with the address counting down, or least-significant first with the address counting up;
- a self-clearing soft reset.

Written data lands in a buffer bank. The buffer bank reaches the active bank, which drives the rest of the chip, only when the `updateStb` input pulses. A bank-select register chooses which of the two banks a read returns. The SPI pins are sampled by the system clock through synchronisers, so the SPI clock must run several times slower than `clk`.

Top module: `spiRegPort`

## Requirements
- R1: A transaction starts when `csN` falls. It opens with a 16-bit instruction: bit 15 = 1 for read and 0 for write, bits 14:13 = byte count minus one, bits 12:0 = start address. The data bytes follow. Data is sampled on rising `sclk` edges and read data changes on falling edges.
- R2: With bit 6 of register 0 cleared (the default), the instruction and all data bytes travel MSB first, and the address decrements after each data byte.
- R3: With bit 6 of register 0 set, the instruction and all data bytes travel LSB first, and the address increments after each data byte.
- R4: A write to a general register changes only its buffer copy. A one-cycle `updateStb` pulse copies every buffer register into its active copy in the same clock. `activeRegs` byte i shows active register i, except that bytes 0 and 4 show the live contents of registers 0 and 4.
- R5: Bit 0 of register 4 selects the bank that reads return: 0 (the default) returns the buffer bank, 1 returns the active bank. Registers 0 and 4 take effect as soon as they are written.
- R6: With bit 7 of register 0 cleared (three-wire mode), read data appears on `sdioOut`. `sdioOe` is high only during the data phase of a read. `sdoOe` stays low.
- R7: With bit 7 of register 0 set (four-wire mode), read data appears on `sdoOut`. `sdoOe` is high only during the data phase of a read. `sdioOe` stays low.
- R8: Writing register 0 with bit 5 set returns every register, including register 0, to zero. Bit 5 always reads back as 0.
- R9: Register 0 reads back as its upper nibble followed by that nibble reversed: bit 0 = bit 7, bit 1 = bit 6, bit 2 = bit 5, bit 3 = bit 4. On a write, bits 7:4 decide the setting and bits 3:0 are ignored.
- R10: Raising `csN` before a byte completes discards that byte. The next transaction starts from a fresh instruction.
- R11: Writes to addresses at or above the register count are ignored, and reads from those addresses return 0x00.
- R12: After reset all registers are zero, both output enables are low, and `activeRegs` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock from the host |
| csN | input | 1 | Active-low chip select |
| sdioIn | input | 1 | Shared data line, input side |
| sdioOut | output | 1 | Shared data line, output side |
| sdioOe | output | 1 | Output enable for the shared data line |
| sdoOut | output | 1 | Dedicated read-data output |
| sdoOe | output | 1 | Output enable for the dedicated output |
| updateStb | input | 1 | Copies the buffer bank into the active bank |
| activeRegs | output | NUM_REGS*8 | Active register contents, register i in byte i |

## Verification
The hardest situation to reach from the pins is a change in port behaviour between transactions. A write to register 0 is shifted in the old bit order, but every later instruction has to use the new order and, if the pin mode changed, return data on the other output. The bench walks through that sequence: MSB-first three-wire, then LSB-first, then LSB-first four-wire, then MSB-first four-wire. It reads back after each step. A soft reset issued in four-wire mode must then bring the port back to three-wire MSB-first with no other action.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_INSTR, ST_DATA, ST_DONE} spiState_e;

  typedef struct packed {
    logic       sampleEn;
    logic       fallEn;
    logic       instrDone;
    logic       byteDone;
    logic       dataPhase;
    logic [2:0] bitIdx;
  } spiStrobe_t;

  localparam int CFG_ADDR  = 0;
  localparam int BANK_ADDR = 4;
endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INSTR_W     = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       sdioIn,
  input  logic       lastByte,
  output spiStrobe_t strb,
  output logic       rxBit
);
  localparam int CNT_W = $clog2(INSTR_W);

  logic [SYNC_STAGES-1:0] sclkSync, csSync, dSync;
  logic sclkPrev, sclkS, csS, rise, fall;
  logic [CNT_W-1:0] cnt;
  spiState_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      dSync    <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      dSync    <= {dSync[SYNC_STAGES-2:0], sdioIn};
      sclkPrev <= sclkS;
    end
  end

  assign sclkS = sclkSync[SYNC_STAGES-1];
  assign csS   = csSync[SYNC_STAGES-1];
  assign rxBit = dSync[SYNC_STAGES-1];
  assign rise  = sclkS & ~sclkPrev;
  assign fall  = ~sclkS & sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (csS) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_INSTR;
          cnt   <= '0;
        end
        ST_INSTR: if (rise) begin
          if (cnt == CNT_W'(INSTR_W - 1)) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_DATA: if (rise) begin
          if (cnt == CNT_W'(7)) begin
            cnt <= '0;
            if (lastByte) state <= ST_DONE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb           = '0;
    strb.sampleEn  = rise && !csS && (state == ST_INSTR || state == ST_DATA);
    strb.instrDone = rise && !csS && state == ST_INSTR && cnt == CNT_W'(INSTR_W - 1);
    strb.byteDone  = rise && !csS && state == ST_DATA && cnt == CNT_W'(7);
    strb.fallEn    = fall && !csS && state == ST_DATA;
    strb.dataPhase = !csS && state == ST_DATA;
    strb.bitIdx    = cnt[2:0];
  end
endmodule

// File: rtl/spiRegData.sv
module spiRegData
  import spiRegPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 13,
  parameter int LEN_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  spiStrobe_t            strb,
  input  logic                  rxBit,
  input  logic                  updateStb,
  output logic                  lastByte,
  output logic                  sdioOut,
  output logic                  sdioOe,
  output logic                  sdoOut,
  output logic                  sdoOe,
  output logic [NUM_REGS*8-1:0] activeRegs
);
  localparam int INSTR_W = 1 + LEN_W + ADDR_W;
  localparam int IDX_W   = $clog2(NUM_REGS);

  logic [INSTR_W-1:0] shiftQ, shiftNext;
  logic [ADDR_W-1:0]  addrQ, addrStep, instrAddr;
  logic [LEN_W-1:0]   lenLeftQ, instrLen;
  logic               instrRw, isReadQ;
  logic               fourWireQ, lsbFirstQ, bankActQ;
  logic               outBitQ, inRange, wrEn, softRst;
  logic [IDX_W-1:0]   idx;
  logic [7:0]         rxByte, readByte, cfgView;
  logic [7:0]         bufQ [NUM_REGS];
  logic [7:0]         actQ [NUM_REGS];

  // Input shift path: bit order follows the live configuration.
  assign shiftNext = lsbFirstQ ? {rxBit, shiftQ[INSTR_W-1:1]}
                               : {shiftQ[INSTR_W-2:0], rxBit};
  assign rxByte    = lsbFirstQ ? shiftNext[INSTR_W-1 -: 8] : shiftNext[7:0];
  assign instrRw   = shiftNext[INSTR_W-1];
  assign instrLen  = shiftNext[INSTR_W-2 -: LEN_W];
  assign instrAddr = shiftNext[ADDR_W-1:0];

  assign addrStep = lsbFirstQ ? addrQ + ADDR_W'(1) : addrQ - ADDR_W'(1);
  assign inRange  = addrQ < ADDR_W'(NUM_REGS);
  assign idx      = addrQ[IDX_W-1:0];
  assign lastByte = (lenLeftQ == '0);

  assign wrEn    = strb.byteDone && !isReadQ && inRange;
  assign softRst = wrEn && idx == IDX_W'(CFG_ADDR) && rxByte[5];

  // Upper nibble stored, lower nibble presented as its mirror.
  assign cfgView = {fourWireQ, lsbFirstQ, 1'b0, 1'b0, 1'b0, 1'b0, lsbFirstQ, fourWireQ};

  always_comb begin
    if (!inRange)                        readByte = 8'h00;
    else if (idx == IDX_W'(CFG_ADDR))    readByte = cfgView;
    else if (idx == IDX_W'(BANK_ADDR))   readByte = {7'b0, bankActQ};
    else if (bankActQ)                   readByte = actQ[idx];
    else                                 readByte = bufQ[idx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ   <= '0;
      addrQ    <= '0;
      lenLeftQ <= '0;
      isReadQ  <= 1'b0;
      outBitQ  <= 1'b0;
    end else begin
      if (strb.sampleEn) shiftQ <= shiftNext;
      if (strb.instrDone) begin
        addrQ    <= instrAddr;
        lenLeftQ <= instrLen;
        isReadQ  <= instrRw;
      end else if (strb.byteDone) begin
        addrQ    <= addrStep;
        lenLeftQ <= lenLeftQ - LEN_W'(1);
      end
      if (strb.fallEn)
        outBitQ <= lsbFirstQ ? readByte[strb.bitIdx] : readByte[3'd7 - strb.bitIdx];
    end
  end

  // Port configuration and bank select act immediately.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fourWireQ <= 1'b0;
      lsbFirstQ <= 1'b0;
      bankActQ  <= 1'b0;
    end else if (softRst) begin
      fourWireQ <= 1'b0;
      lsbFirstQ <= 1'b0;
      bankActQ  <= 1'b0;
    end else if (wrEn && idx == IDX_W'(CFG_ADDR)) begin
      fourWireQ <= rxByte[7];
      lsbFirstQ <= rxByte[6];
    end else if (wrEn && idx == IDX_W'(BANK_ADDR)) begin
      bankActQ <= rxByte[0];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSlot
    if (g == CFG_ADDR || g == BANK_ADDR) begin : gCtl
      assign bufQ[g] = 8'h00;
      assign actQ[g] = 8'h00;
      assign activeRegs[g*8 +: 8] = (g == CFG_ADDR) ? cfgView : {7'b0, bankActQ};
    end else begin : gGen
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bufQ[g] <= 8'h00;
          actQ[g] <= 8'h00;
        end else if (softRst) begin
          bufQ[g] <= 8'h00;
          actQ[g] <= 8'h00;
        end else begin
          if (wrEn && idx == IDX_W'(g)) bufQ[g] <= rxByte;
          if (updateStb)                actQ[g] <= bufQ[g];
        end
      end
      assign activeRegs[g*8 +: 8] = actQ[g];
    end
  end

  assign sdioOut = outBitQ;
  assign sdoOut  = outBitQ;
  assign sdioOe  = strb.dataPhase && isReadQ && !fourWireQ;
  assign sdoOe   = strb.dataPhase && isReadQ && fourWireQ;
endmodule

// File: rtl/spiRegPort.sv
module spiRegPort
  import spiRegPkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int ADDR_W      = 13,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclk,
  input  logic                  csN,
  input  logic                  sdioIn,
  output logic                  sdioOut,
  output logic                  sdioOe,
  output logic                  sdoOut,
  output logic                  sdoOe,
  input  logic                  updateStb,
  output logic [NUM_REGS*8-1:0] activeRegs
);
  localparam int INSTR_W = 1 + LEN_W + ADDR_W;

  spiStrobe_t strb;
  logic rxBit, lastByte;

  spiRegCtrl #(.SYNC_STAGES(SYNC_STAGES), .INSTR_W(INSTR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .lastByte(lastByte), .strb(strb), .rxBit(rxBit)
  );

  spiRegData #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rxBit(rxBit), .updateStb(updateStb),
    .lastByte(lastByte), .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut),
    .sdoOe(sdoOe), .activeRegs(activeRegs)
  );
endmodule

// File: rtl/spiRegChk.sv
module spiRegChk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  csN,
  input logic                  updateStb,
  input logic                  sdioOe,
  input logic                  sdoOe,
  input logic [NUM_REGS*8-1:0] activeRegs
);
  // R7
  oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sdioOe && sdoOe));

  // R6
  sdio_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> !activeRegs[7]);

  // R7
  sdo_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |-> activeRegs[7]);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3) && $past(csN, 4))
      |-> (!sdioOe && !sdoOe));

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3) && $past(csN, 4) && !$past(updateStb))
      |-> $stable(activeRegs));
endmodule

bind spiRegPort spiRegChk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .updateStb(updateStb),
  .sdioOe(sdioOe), .sdoOe(sdoOe), .activeRegs(activeRegs)
);

// File: tb/spiRegPort_tb.sv
`timescale 1ns/1ps
module spiRegPort_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, sdioIn = 1'b0, updateStb = 1'b0;
  logic sdioOut, sdioOe, sdoOut, sdoOe;
  logic [63:0] activeRegs;

  int nChecks = 0, nFail = 0;
  bit idle = 1'b1, done = 1'b0;

  logic [7:0] mBuf [8];
  logic [7:0] mAct [8];
  logic mFw = 1'b0, mLsb = 1'b0, mBank = 1'b0;

  always #4 clk = ~clk;

  spiRegPort dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .updateStb(updateStb), .activeRegs(activeRegs)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cfgView();
    return {mFw, mLsb, 4'b0000, mLsb, mFw};
  endfunction

  function automatic logic [63:0] modelVec();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = mAct[i];
    v[7:0]   = cfgView();
    v[39:32] = {7'b0, mBank};
    return v;
  endfunction

  function automatic logic [7:0] modelRead(input int a);
    if (a >= 8) return 8'h00;
    if (a == 0) return cfgView();
    if (a == 4) return {7'b0, mBank};
    return mBank ? mAct[a] : mBuf[a];
  endfunction

  function automatic int stepAddr(input int a, input logic lsb);
    return lsb ? ((a + 1) & 16'h1FFF) : ((a - 1) & 16'h1FFF);
  endfunction

  task automatic modelSoftReset();
    for (int i = 0; i < 8; i++) begin
      mBuf[i] = 8'h00;
      mAct[i] = 8'h00;
    end
    mFw = 1'b0; mLsb = 1'b0; mBank = 1'b0;
  endtask

  // Model of the update strobe, same edge as the design.
  always @(posedge clk)
    if (rstN && updateStb)
      for (int i = 0; i < 8; i++) mAct[i] = mBuf[i];

  // Clock-by-clock comparison while the bus is quiet (R4, R12).
  always @(negedge clk)
    if (rstN && idle && !done) begin
      chk("R4 active bank", activeRegs, modelVec());
      chk("R12 idle enables", {sdioOe, sdoOe}, 2'b00);
    end

  task automatic xferBit(input logic b, output logic o);
    sdioIn = b;
    repeat (HALF) @(negedge clk);
    o = mFw ? sdoOut : sdioOut;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sendWord(input logic [15:0] w, input int width, output logic [15:0] got);
    got = '0;
    for (int i = 0; i < width; i++) begin
      int pos;
      logic o;
      pos = mLsb ? i : width - 1 - i;
      xferBit(w[pos], o);
      got[pos] = o;
    end
  endtask

  task automatic spiBegin();
    idle = 1'b0;
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spiEnd();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic spiWrite(input int addr, input int n, input logic [7:0] d [4], input string req);
    logic [15:0] got;
    int a;
    logic lsb0;
    lsb0 = mLsb;
    spiBegin();
    sendWord({1'b0, 2'(n - 1), 13'(addr)}, 16, got);
    chk({req, " write enables"}, {sdioOe, sdoOe}, 2'b00);
    for (int k = 0; k < n; k++) sendWord({8'h00, d[k]}, 8, got);
    spiEnd();
    a = addr;
    for (int k = 0; k < n; k++) begin
      if (a == 0) begin
        if (d[k][5]) modelSoftReset();
        else begin mFw = d[k][7]; mLsb = d[k][6]; end
      end else if (a == 4) mBank = d[k][0];
      else if (a < 8) mBuf[a] = d[k];
      a = stepAddr(a, lsb0);
    end
    idle = 1'b1;
  endtask

  task automatic spiRead(input int addr, input int n, input string req);
    logic [15:0] got;
    int a;
    a = addr;
    spiBegin();
    sendWord({1'b1, 2'(n - 1), 13'(addr)}, 16, got);
    for (int k = 0; k < n; k++) begin
      chk({req, mFw ? " R7 enables" : " R6 enables"}, {sdioOe, sdoOe}, {!mFw, mFw});
      sendWord(16'h0000, 8, got);
      chk({req, " read data"}, got[7:0], modelRead(a));
      a = stepAddr(a, mLsb);
    end
    spiEnd();
    idle = 1'b1;
  endtask

  task automatic pulseUpdate();
    @(negedge clk);
    updateStb = 1'b1;
    @(negedge clk);
    updateStb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [15:0] junk;
    for (int i = 0; i < 8; i++) begin mBuf[i] = 8'h00; mAct[i] = 8'h00; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset regs", activeRegs, 64'h0);
    chk("R12 reset enables", {sdioOe, sdoOe}, 2'b00);

    // R1 R2: three bytes MSB first, address decrements
    spiWrite(3, 3, '{8'hA1, 8'hB2, 8'hC3, 8'h00}, "R2");
    spiRead(3, 3, "R1 R2");
    // R4: active bank untouched until strobe
    chk("R4 before strobe", activeRegs[31:8], 24'h0);
    pulseUpdate();
    chk("R4 after strobe", activeRegs[31:8], 24'hA1B2C3);

    // R5: bank select
    spiWrite(6, 2, '{8'h5A, 8'h3C, 8'h00, 8'h00}, "R5");
    spiRead(6, 2, "R5 buffer bank");
    spiWrite(4, 1, '{8'h01, 8'h00, 8'h00, 8'h00}, "R5");
    spiRead(6, 2, "R5 active bank");
    spiRead(3, 1, "R5 active bank");
    spiRead(4, 1, "R5 select readback");
    spiWrite(4, 1, '{8'h00, 8'h00, 8'h00, 8'h00}, "R5");

    // R9 R3: mismatched mirror, upper nibble wins
    spiWrite(0, 1, '{8'h40, 8'h00, 8'h00, 8'h00}, "R9");
    spiRead(0, 1, "R9 R3 mirror");
    spiWrite(1, 2, '{8'h11, 8'h22, 8'h00, 8'h00}, "R3");
    spiRead(1, 3, "R3 increment");

    // R7: four-wire, LSB first then MSB first
    spiWrite(0, 1, '{8'hC3, 8'h00, 8'h00, 8'h00}, "R7");
    spiRead(2, 1, "R7 lsb");
    spiWrite(0, 1, '{8'h81, 8'h00, 8'h00, 8'h00}, "R7");
    spiRead(3, 2, "R7 msb");
    spiRead(0, 1, "R7 R9 cfg");

    // R11: out-of-range address
    spiWrite(9, 1, '{8'h77, 8'h00, 8'h00, 8'h00}, "R11");
    spiRead(9, 1, "R11 high addr");
    spiRead(13'h1FFF, 1, "R11 top addr");
    spiRead(1, 1, "R11 no alias");

    // R10: abort mid byte
    spiBegin();
    sendWord({1'b0, 2'd0, 13'd2}, 16, junk);
    sendWord(16'h00FF, 5, junk);
    spiEnd();
    idle = 1'b1;
    spiRead(2, 1, "R10 aborted byte");
    spiWrite(7, 1, '{8'h99, 8'h00, 8'h00, 8'h00}, "R10");
    spiRead(7, 1, "R10 next transaction");

    // R8: soft reset from four-wire mode
    pulseUpdate();
    chk("R4 second strobe", activeRegs[63:56], 64'h99);
    spiWrite(0, 1, '{8'h24, 8'h00, 8'h00, 8'h00}, "R8");
    chk("R8 soft reset", activeRegs, 64'h0);
    spiRead(0, 1, "R8 R6 cfg cleared");
    spiRead(7, 2, "R8 R6 regs cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule